// File: doc/BRIEF.md
# Coherence Flit Encoder (memory side to L1 side)

This block sits next to a memory-side cache controller. It turns one coherence request into a packet of 40-bit flits for the network that carries traffic from the memory-side caches to the L1 caches. A request descriptor arrives on a valid/ready port. The descriptor holds a kind code, the target L1 id, the source id, an update-table slot, a cache line number, the first word index, a set and way pair, a broadcast bounding box and a data word count. For update packets, the data words and their byte enables come in on a second valid/ready stream. Flits leave on a valid/ready output.

Four packet shapes are built:
- **Update**: a header flit, a line flit, then 1 to `MAX_WORDS` data flits.
- **Invalidate**: two flits.
- **Bounding-box broadcast invalidate**: two flits, with the broadcast flag set in bit 0 of the first flit.
- **Cleanup acknowledge**: one flit.

Descriptors that cannot be encoded are dropped. Each one raises a one-cycle error pulse.

The controller is a four-state machine:
- `ST_IDLE`: ready for a request.
- `ST_HEAD0`: first flit.
- `ST_HEAD1`: second flit.
- `ST_DATA`: update payload.

The transitions are:
- **accept_ok**: `ST_IDLE` to `ST_HEAD0`.
- **reject**: `ST_IDLE` to `ST_IDLE`, with the error pulse.
- **ack_done**: `ST_HEAD0` to `ST_IDLE`, for a cleanup acknowledge.
- **head_next**: `ST_HEAD0` to `ST_HEAD1`.
- **short_done**: `ST_HEAD1` to `ST_IDLE`, for invalidate and broadcast.
- **to_payload**: `ST_HEAD1` to `ST_DATA`, for update.
- **word_next**: `ST_DATA` to `ST_DATA`.
- **payload_done**: `ST_DATA` to `ST_IDLE`, on the last word.

Top module: `coh_flit_encoder`

## Requirements
- R1: After reset, `req_ready` is 1 and both `flit_valid` and `req_error` are 0.
- R2: `req_kind` codes are as follows. Code 0 is an update to a data cache and code 1 is an update to an instruction cache. Code 2 is an invalidate to a data cache and code 3 is an invalidate to an instruction cache. Code 4 is a cleanup acknowledge and code 5 is a broadcast invalidate. Codes 6 and 7 are illegal. The first flit of an update or invalidate is, from bit 39 down to bit 0: end flag 0, destination id (14), three zero bits, source id (14), update slot (4), kind code (3), broadcast flag 0.
- R3: The second flit of an update is, from bit 39 down: end flag 0, one zero bit, first word index (4), line number (34). It is followed by exactly `req_count` data flits. Each data flit is: end flag, three zero bits, byte enables (4), word (32). The end flag is 1 only on the last data flit.
- R4: An invalidate is exactly two flits. Both use the update layouts, and the second flit has its end flag set to 1.
- R5: A broadcast invalidate is two flits. The first flit is: end flag 0, bounding box (20, given as xmin, xmax, ymin, ymax at 5 bits each), source id (14), four zero bits, broadcast flag 1. The second flit is: end flag 1, one zero bit, update slot (4), line number (34).
- R6: A cleanup acknowledge is a single flit: end flag 1, destination id (14), three zero bits, set (16), way (2), kind code 4, broadcast flag 0.
- R7: Some accepted requests are rejected: an illegal kind code, or an update with `req_count` equal to 0 or greater than 16. For such a request, `req_error` is 1 in exactly the cycle after acceptance, and no flit is produced.
- R8: While `flit_valid` is 1 and `flit_ready` is 0, `flit_data` holds its value. A data word is consumed only in a cycle where its flit is accepted at the output.
- R9: `req_ready` stays 0 from the cycle after a request is accepted until the final flit of that packet has been accepted. It is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Encoder can take a descriptor |
| req_kind | input | 3 | Packet kind code (see R2) |
| req_dest | input | 14 | Target L1 cache id |
| req_src | input | 14 | Source cache id |
| req_slot | input | 4 | Update-table slot |
| req_line | input | 34 | Cache line number |
| req_widx | input | 4 | First updated word index |
| req_set | input | 16 | Released set index |
| req_way | input | 2 | Released way index |
| req_box | input | 20 | Broadcast bounding box |
| req_count | input | 5 | Number of update data words |
| data_valid | input | 1 | Update data word valid |
| data_ready | output | 1 | Update data word taken |
| data_be | input | 4 | Byte enables of the word |
| data_word | input | 32 | Update data word |
| flit_valid | output | 1 | Output flit valid |
| flit_ready | input | 1 | Output flit accepted by network |
| flit_data | output | 40 | Output flit |
| req_error | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two events can coincide in one cycle: the handshake of the final flit of a packet, and a new descriptor already held valid on the request port. The bench provokes this by putting the next descriptor up, with `req_valid` high, while the current update is still being drained under random output stalls. In every one of those cycles, including the cycle of the final handshake, it requires `req_ready` to be 0. It then requires the waiting request to be taken in the cycle right after. The packet that follows is compared flit by flit against the layouts, which shows that the overlap neither dropped nor merged a request.

// File: rtl/coh_enc_pkg.sv
package coh_enc_pkg;
    localparam int FLIT_W  = 40;
    localparam int ID_W    = 14;
    localparam int SLOT_W  = 4;
    localparam int LINE_W  = 34;
    localparam int WIDX_W  = 4;
    localparam int SET_W   = 16;
    localparam int WAY_W   = 2;
    localparam int BOX_W   = 20;
    localparam int BE_W    = 4;
    localparam int WORD_W  = 32;
    localparam int KIND_W  = 3;

    localparam logic [KIND_W-1:0] K_UPD_D = 3'd0;
    localparam logic [KIND_W-1:0] K_UPD_I = 3'd1;
    localparam logic [KIND_W-1:0] K_INV_D = 3'd2;
    localparam logic [KIND_W-1:0] K_INV_I = 3'd3;
    localparam logic [KIND_W-1:0] K_CLACK = 3'd4;
    localparam logic [KIND_W-1:0] K_BCAST = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HEAD0 = 2'd1,
        ST_HEAD1 = 2'd2,
        ST_DATA  = 2'd3
    } enc_state_t;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ID_W-1:0]   dest;
        logic [ID_W-1:0]   src;
        logic [SLOT_W-1:0] slot;
        logic [LINE_W-1:0] line;
        logic [WIDX_W-1:0] widx;
        logic [SET_W-1:0]  set;
        logic [WAY_W-1:0]  way;
        logic [BOX_W-1:0]  box;
    } coh_desc_t;
endpackage

// File: rtl/coh_req_check.sv
module coh_req_check
    import coh_enc_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS) + 1
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [CNT_W-1:0]  count,
    output logic              is_update,
    output logic              legal
);
    always_comb begin
        is_update = (kind == K_UPD_D) || (kind == K_UPD_I);
        if (kind > K_BCAST)
            legal = 1'b0;
        else if (is_update)
            legal = (count != '0) && (count <= CNT_W'(MAX_WORDS));
        else
            legal = 1'b1;
    end
endmodule

// File: rtl/coh_hdr_fmt.sv
module coh_hdr_fmt
    import coh_enc_pkg::*;
(
    input  coh_desc_t         d,
    output logic [FLIT_W-1:0] head0,
    output logic [FLIT_W-1:0] head1
);
    logic is_inv;

    always_comb begin
        is_inv = (d.kind == K_INV_D) || (d.kind == K_INV_I);
        unique case (d.kind)
            K_BCAST: begin
                head0 = {1'b0, d.box, d.src, 4'b0000, 1'b1};
                head1 = {1'b1, 1'b0, d.slot, d.line};
            end
            K_CLACK: begin
                head0 = {1'b1, d.dest, 3'b000, d.set, d.way, d.kind, 1'b0};
                head1 = '0;
            end
            default: begin
                head0 = {1'b0, d.dest, 3'b000, d.src, d.slot, d.kind, 1'b0};
                head1 = {is_inv, 1'b0, d.widx, d.line};
            end
        endcase
    end
endmodule

// File: rtl/coh_enc_fsm.sv
module coh_enc_fsm
    import coh_enc_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    parameter int CNT_W     = $clog2(MAX_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_legal,
    input  logic [CNT_W-1:0] req_count,
    input  logic             held_update,
    input  logic             held_clack,
    input  logic             data_valid,
    input  logic             flit_ready,
    output logic             req_ready,
    output logic             load,
    output logic             req_error,
    output logic             flit_valid,
    output logic             data_ready,
    output logic             data_last,
    output enc_state_t       state
);
    enc_state_t       state_nx;
    logic [CNT_W-1:0] left_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            left_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= state_nx;
            err_q <= req_valid && req_ready && !req_legal;
            if (load)
                left_q <= req_count;
            else if (state == ST_DATA && data_valid && flit_ready)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid && req_legal) state_nx = ST_HEAD0;
            ST_HEAD0: if (flit_ready) state_nx = held_clack ? ST_IDLE : ST_HEAD1;
            ST_HEAD1: if (flit_ready) state_nx = held_update ? ST_DATA : ST_IDLE;
            ST_DATA:  if (data_valid && flit_ready && data_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        flit_valid = 1'b0;
        data_ready = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_HEAD0: flit_valid = 1'b1;
            ST_HEAD1: flit_valid = 1'b1;
            ST_DATA: begin
                flit_valid = data_valid;
                data_ready = flit_ready;
            end
            default: ;
        endcase
        load      = req_valid && req_ready && req_legal;
        data_last = (left_q == CNT_W'(1));
        req_error = err_q;
    end

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !flit_valid);
    assert_error_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |-> $past(req_valid && req_ready));
    assert_error_no_flit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |-> !flit_valid);
    assert_word_with_flit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_ready) |-> (flit_valid && flit_ready));
endmodule

// File: rtl/coh_flit_encoder.sv
module coh_flit_encoder
    import coh_enc_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    localparam int CNT_W    = $clog2(MAX_WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ID_W-1:0]   req_dest,
    input  logic [ID_W-1:0]   req_src,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [LINE_W-1:0] req_line,
    input  logic [WIDX_W-1:0] req_widx,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [BOX_W-1:0]  req_box,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              data_valid,
    output logic              data_ready,
    input  logic [BE_W-1:0]   data_be,
    input  logic [WORD_W-1:0] data_word,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit_data,
    output logic              req_error
);
    coh_desc_t         held_q;
    logic              in_update, in_legal, held_update;
    logic              load, data_last;
    logic              unused_upd;
    logic [FLIT_W-1:0] head0, head1;
    enc_state_t        state;

    coh_req_check #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_check (
        .kind(req_kind), .count(req_count), .is_update(in_update), .legal(in_legal));

    coh_req_check #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_held_kind (
        .kind(held_q.kind), .count(CNT_W'(1)), .is_update(held_update), .legal(unused_upd));

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (load)
            held_q <= '{kind: req_kind, dest: req_dest, src: req_src, slot: req_slot,
                        line: req_line, widx: req_widx, set: req_set, way: req_way,
                        box: req_box};
    end

    coh_hdr_fmt u_fmt (.d(held_q), .head0(head0), .head1(head1));

    coh_enc_fsm #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(in_legal),
        .req_count(req_count), .held_update(held_update),
        .held_clack(held_q.kind == K_CLACK), .data_valid(data_valid),
        .flit_ready(flit_ready), .req_ready(req_ready), .load(load),
        .req_error(req_error), .flit_valid(flit_valid), .data_ready(data_ready),
        .data_last(data_last), .state(state));

    always_comb begin
        unique case (state)
            ST_HEAD0: flit_data = head0;
            ST_HEAD1: flit_data = head1;
            ST_DATA:  flit_data = {data_last, 3'b000, data_be, data_word};
            default:  flit_data = '0;
        endcase
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data)));
    assert_end_frees_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_ready && flit_data[FLIT_W-1]) |=> req_ready);
    assert_bcast_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && state == ST_HEAD0 && held_q.kind == K_BCAST) |-> flit_data[0]);
    assert_legal_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (in_update == (req_kind < K_INV_D)));
endmodule

// File: tb/coh_flit_encoder_test.sv
module coh_flit_encoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 0, req_ready;
    logic [2:0]  req_kind = 0;
    logic [13:0] req_dest = 0, req_src = 0;
    logic [3:0]  req_slot = 0, req_widx = 0;
    logic [33:0] req_line = 0;
    logic [15:0] req_set = 0;
    logic [1:0]  req_way = 0;
    logic [19:0] req_box = 0;
    logic [4:0]  req_count = 0;
    logic        data_valid = 0, data_ready;
    logic [3:0]  data_be = 0;
    logic [31:0] data_word = 0;
    logic        flit_valid, flit_ready = 0, req_error;
    logic [39:0] flit_data;

    coh_flit_encoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_dest(req_dest), .req_src(req_src), .req_slot(req_slot),
        .req_line(req_line), .req_widx(req_widx), .req_set(req_set), .req_way(req_way),
        .req_box(req_box), .req_count(req_count), .data_valid(data_valid),
        .data_ready(data_ready), .data_be(data_be), .data_word(data_word),
        .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data),
        .req_error(req_error));

    int total = 0;
    int bad = 0;

    logic [31:0] pw [0:15];
    logic [3:0]  pb [0:15];
    logic [31:0] ew [0:15];
    logic [3:0]  eb [0:15];
    logic [2:0]  e_kind;
    logic [13:0] e_dest, e_src;
    logic [3:0]  e_slot, e_widx;
    logic [33:0] e_line;
    logic [15:0] e_set;
    logic [1:0]  e_way;
    logic [19:0] e_box;
    logic [4:0]  e_n;
    logic [39:0] got [0:19];

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_upd(input logic [2:0] k);
        return k < 3'd2;
    endfunction

    function automatic bit is_bad(input logic [2:0] k, input logic [4:0] n);
        return (k > 3'd5) || (is_upd(k) && (n == 0 || n > 16));
    endfunction

    function automatic int exp_len();
        if (is_upd(e_kind)) return 2 + int'(e_n);
        if (e_kind == 3'd4) return 1;
        return 2;
    endfunction

    function automatic string tag_of(input int i);
        if (e_kind == 3'd5) return "R5";
        if (e_kind == 3'd4) return "R6";
        if (e_kind >= 3'd2) return (i == 0) ? "R2" : "R4";
        return (i == 0) ? "R2" : "R3";
    endfunction

    function automatic logic [39:0] exp_flit(input int i);
        if (e_kind == 3'd4)
            return {1'b1, e_dest, 3'b000, e_set, e_way, 3'd4, 1'b0};
        if (e_kind == 3'd5)
            return (i == 0) ? {1'b0, e_box, e_src, 4'b0000, 1'b1}
                            : {1'b1, 1'b0, e_slot, e_line};
        if (i == 0) return {1'b0, e_dest, 3'b000, e_src, e_slot, e_kind, 1'b0};
        if (i == 1) return {!is_upd(e_kind), 1'b0, e_widx, e_line};
        return {(i == int'(e_n) + 1), 3'b000, eb[i-2], ew[i-2]};
    endfunction

    task automatic present(input logic [2:0] k, input logic [4:0] n);
        req_kind  = k;
        req_count = n;
        req_dest  = 14'($urandom);
        req_src   = 14'($urandom);
        req_slot  = 4'($urandom);
        req_widx  = 4'($urandom);
        req_line  = {2'($urandom), 32'($urandom)};
        req_set   = 16'($urandom);
        req_way   = 2'($urandom);
        req_box   = 20'($urandom);
        for (int i = 0; i < 16; i++) begin
            pw[i] = $urandom;
            pb[i] = 4'($urandom);
        end
        req_valid = 1'b1;
    endtask

    task automatic do_pkt(input bit overlap, input logic [2:0] nk, input logic [4:0] nn);
        int nf, di, lim;
        bit done, stall, take;
        logic [39:0] prev;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        e_kind = req_kind; e_dest = req_dest; e_src = req_src; e_slot = req_slot;
        e_widx = req_widx; e_line = req_line; e_set = req_set; e_way = req_way;
        e_box = req_box; e_n = req_count;
        for (int i = 0; i < 16; i++) begin
            ew[i] = pw[i];
            eb[i] = pb[i];
        end
        @(negedge clk);
        if (overlap) present(nk, nn);
        else req_valid = 1'b0;
        if (is_bad(e_kind, e_n)) begin
            #1;
            check(req_error == 1'b1, "R7 error pulse", 64'(req_error), 64'd1);
            check(flit_valid == 1'b0, "R7 no flit", 64'(flit_valid), 64'd0);
            @(negedge clk);
            #1;
            check(req_error == 1'b0 && flit_valid == 1'b0, "R7 single pulse",
                  64'({req_error, flit_valid}), 64'd0);
            return;
        end
        nf = 0; di = 0; done = 0; stall = 0; prev = '0;
        lim = is_upd(e_kind) ? int'(e_n) : 0;
        forever begin
            take = 0;
            flit_ready = ($urandom % 4) != 0;
            if (!data_valid && di < lim && ($urandom % 3) != 0) begin
                data_valid = 1'b1;
                data_be    = eb[di];
                data_word  = ew[di];
            end
            #1;
            if (overlap)
                check(req_ready == 1'b0, "R9 busy while draining", 64'(req_ready), 64'd0);
            if (stall)
                check(flit_valid && flit_data == prev, "R8 hold under stall",
                      64'(flit_data), 64'(prev));
            stall = flit_valid && !flit_ready;
            prev  = flit_data;
            if (flit_valid && flit_ready) begin
                got[nf] = flit_data;
                if (nf < 19) nf++;
                if (flit_data[39]) done = 1;
            end
            if (data_valid && data_ready) begin
                di++;
                take = 1;
            end
            @(negedge clk);
            if (take) data_valid = 1'b0;
            if (done) break;
        end
        flit_ready = 1'b0;
        data_valid = 1'b0;
        check(nf == exp_len(), {tag_of(1), " flit count"}, 64'(nf), 64'(exp_len()));
        check(di == lim, "R8 words consumed", 64'(di), 64'(lim));
        for (int i = 0; i < nf && i < exp_len(); i++)
            check(got[i] == exp_flit(i), {tag_of(i), " flit layout"}, 64'(got[i]),
                  64'(exp_flit(i)));
        #1;
        check(req_ready == 1'b1 && flit_valid == 1'b0, "R9 ready after last flit",
              64'({req_ready, flit_valid}), 64'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] k;
        logic [4:0] n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(req_ready == 1 && flit_valid == 0 && req_error == 0, "R1 reset state",
              64'({req_ready, flit_valid, req_error}), 64'b100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1 && flit_valid == 0 && req_error == 0, "R1 after reset",
              64'({req_ready, flit_valid, req_error}), 64'b100);
        @(negedge clk);

        present(3'd0, 5'd1);  do_pkt(0, 0, 0);
        present(3'd1, 5'd16); do_pkt(0, 0, 0);
        present(3'd2, 5'd0);  do_pkt(0, 0, 0);
        present(3'd3, 5'd9);  do_pkt(0, 0, 0);
        present(3'd4, 5'd3);  do_pkt(0, 0, 0);
        present(3'd5, 5'd0);  do_pkt(0, 0, 0);
        present(3'd0, 5'd0);  do_pkt(0, 0, 0);
        present(3'd1, 5'd17); do_pkt(0, 0, 0);
        present(3'd6, 5'd2);  do_pkt(0, 0, 0);
        present(3'd7, 5'd2);  do_pkt(0, 0, 0);
        present(3'd0, 5'd4);  do_pkt(1, 3'd5, 5'd0);
        do_pkt(1, 3'd1, 5'd7);
        do_pkt(1, 3'd4, 5'd0);
        do_pkt(0, 0, 0);

        for (int r = 0; r < 60; r++) begin
            k = 3'($urandom % 8);
            n = 5'($urandom % 19);
            if (($urandom % 4) == 0 && !is_bad(k, n)) begin
                present(k, n);
                do_pkt(1, 3'($urandom % 6), 5'(1 + $urandom % 16));
                do_pkt(0, 0, 0);
            end else begin
                present(k, n);
                do_pkt(0, 0, 0);
            end
        end
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule